// File: doc/BRIEF.md
# SMT Fetch Thread Priority Selector

This block sits in the fetch stage of a simultaneous multithreading core. The program counters are kept per thread, but every thread shares the fetch bandwidth. Each cycle the block picks up to `SLOTS` hardware threads that may fetch. With the defaults it handles four threads and grants two of them, so each granted thread takes half of the fetch width.

For every thread it keeps three saturating occupancy counters. The first counts instructions in the decode, rename and issue-queue stages. The second counts branches in those same stages. The third counts outstanding data-cache misses. Upstream logic drives one increment pulse and one decrement pulse per counter.

A two-bit policy input picks how threads are ranked. Under a counter policy, the threads with the smallest values of the chosen counter win. Under the rotation policy, the next eligible threads in turn win. A stalled thread is never chosen. Ties are broken in rotating order, starting just after the last thread granted, so no thread starves.

The block is built around one small state machine. Its state is the active policy, with four states: `POL_OCC`, `POL_BRANCH`, `POL_MISS` and `POL_ROTATE`. On every clock edge it moves to the state encoded on `policy_i`, so any state can move to any other. The transition is named after its target: enter-occupancy on code 0, enter-branch on code 1, enter-miss on code 2 and enter-rotate on code 3. Holding the same code keeps the current state.

A separate output process registers the grant that was ranked from the previous state and the previous counter values.

Top module: `fetch_prio_sel`

## Requirements
- R1: While `rst_n` is low, `grant_o` is all zero and `top_vld_o` is 0. After reset every counter is 0, the policy state is `POL_OCC` and the rotation pointer holds thread NT-1, so thread 0 comes first in rotation order.
- R2: Each per-thread counter changes by +1 on its increment pulse and by -1 on its decrement pulse. When both pulses arrive in the same cycle, the counter keeps its value.
- R3: Each 6-bit counter saturates. An increment at 63 leaves it at 63, and a decrement at 0 leaves it at 0.
- R4: With policy code 0, the block grants the `SLOTS` unstalled threads that have the smallest instruction-occupancy counts. If fewer threads are unstalled, it grants all of them. `top_id_o` is the single best thread.
- R5: With policy code 1, ranking uses the in-flight branch counts, and the smallest count wins.
- R6: With policy code 2, ranking uses the outstanding data-cache miss counts, and the smallest count wins.
- R7: With policy code 3, the block grants the first `SLOTS` unstalled threads in rotation order that starts just after the pointer.
- R8: Equal counts are ordered by rotation: the thread nearest after the pointer ranks first. After any non-empty grant, the pointer moves to the lowest-ranked granted thread. `top_vld_o` high implies `grant_o[top_id_o]` is set.
- R9: A thread whose `stall_i` bit is set is never granted. If every thread is stalled, `grant_o` is zero, `top_vld_o` is 0 and the pointer does not move.
- R10: The policy input is sampled only at a clock edge. Changing the policy clears no counter, so ranking continues from the accumulated counts.
- R11: The grant is registered. A grant seen after edge k is ranked from the stall inputs and the pointer at edge k, and from the policy and counter values loaded at edge k-1. Events sampled at edge k-1 therefore show up after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Ranking policy code: 0 occupancy, 1 branch, 2 miss, 3 rotate |
| stall_i | input | NT | Per-thread stall flags; a set bit blocks the grant |
| inst_inc_i | input | NT | An instruction of the thread entered the front-end stages |
| inst_dec_i | input | NT | An instruction of the thread left the front-end stages |
| br_inc_i | input | NT | A branch of the thread entered the front-end stages |
| br_dec_i | input | NT | A branch of the thread left the stages or resolved |
| miss_inc_i | input | NT | A data-cache miss of the thread was issued |
| miss_dec_i | input | NT | A data-cache miss of the thread returned |
| grant_o | output | NT | Mask of the threads allowed to fetch this cycle |
| top_id_o | output | log2(NT) | Highest-ranked granted thread |
| top_vld_o | output | 1 | At least one thread is granted |

## Verification
A stall input counts one edge before the grant that it affects. A counter event or a policy change counts two edges before, because the counter or the state register is loaded first and the grant register only after that. The bench drives every input on the falling edge. Its model ranks threads at each rising edge using the counters, policy and pointer as they stood before that edge, and only then applies the events and the new policy sampled at that edge. Grant, top thread and valid are compared at the following falling edge. As a result each expected value sits at exactly the register depth given in R11.

// File: rtl/fetch_prio_pkg.sv
package fetch_prio_pkg;

    typedef enum logic [1:0] {
        POL_OCC    = 2'd0,
        POL_BRANCH = 2'd1,
        POL_MISS   = 2'd2,
        POL_ROTATE = 2'd3
    } fetch_pol_e;

    localparam int NUM_METRICS = 3;
    localparam int MET_OCC     = 0;
    localparam int MET_BR      = 1;
    localparam int MET_MISS    = 2;

endpackage

// File: rtl/fetch_sat_ctr.sv
module fetch_sat_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] CNT_MIN = '0;

    logic up_ok;
    logic dn_ok;

    // Opposite pulses cancel; each direction stops at its rail.
    assign up_ok = inc_i && !dec_i && (cnt_o != CNT_MAX);
    assign dn_ok = dec_i && !inc_i && (cnt_o != CNT_MIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= CNT_MIN;
        end else if (up_ok) begin
            cnt_o <= cnt_o + 1'b1;
        end else if (dn_ok) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

endmodule

// File: rtl/fetch_rank.sv
module fetch_rank #(
    parameter int NT    = 4,
    parameter int CW    = 6,
    parameter int SLOTS = 2,
    localparam int IDW  = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0][CW-1:0] key_i,
    input  logic [NT-1:0]         elig_i,
    input  logic [IDW-1:0]        ptr_i,
    output logic [NT-1:0]         grant_o,
    output logic [IDW-1:0]        top_o,
    output logic [IDW-1:0]        last_o,
    output logic                  any_o
);

    logic [NT-1:0]  taken;
    logic           found;
    logic [IDW-1:0] best;
    logic [CW-1:0]  best_key;
    int             idx;

    // SLOTS rounds; each round takes the smallest key among the remaining
    // eligible threads, scanning in rotation order after the pointer so the
    // first thread met wins an equal key.
    always_comb begin
        taken    = '0;
        top_o    = '0;
        last_o   = ptr_i;
        any_o    = 1'b0;
        found    = 1'b0;
        best     = '0;
        best_key = '0;
        idx      = 0;
        for (int s = 0; s < SLOTS; s++) begin
            found    = 1'b0;
            best     = '0;
            best_key = '0;
            for (int o = 1; o <= NT; o++) begin
                idx = (int'(ptr_i) + o) % NT;
                if (elig_i[idx] && !taken[idx] &&
                    (!found || (key_i[idx] < best_key))) begin
                    found    = 1'b1;
                    best     = idx[IDW-1:0];
                    best_key = key_i[idx];
                end
            end
            if (found) begin
                taken[best] = 1'b1;
                last_o      = best;
                if (s == 0) begin
                    top_o = best;
                    any_o = 1'b1;
                end
            end
        end
        grant_o = taken;
    end

endmodule

// File: rtl/fetch_prio_sel.sv
module fetch_prio_sel
    import fetch_prio_pkg::*;
#(
    parameter int NT    = 4,
    parameter int CW    = 6,
    parameter int SLOTS = 2,
    localparam int IDW  = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     policy_i,
    input  logic [NT-1:0]  stall_i,
    input  logic [NT-1:0]  inst_inc_i,
    input  logic [NT-1:0]  inst_dec_i,
    input  logic [NT-1:0]  br_inc_i,
    input  logic [NT-1:0]  br_dec_i,
    input  logic [NT-1:0]  miss_inc_i,
    input  logic [NT-1:0]  miss_dec_i,
    output logic [NT-1:0]  grant_o,
    output logic [IDW-1:0] top_id_o,
    output logic           top_vld_o
);

    localparam logic [IDW-1:0] PTR_RST = IDW'(NT - 1);

    logic [NUM_METRICS-1:0][NT-1:0]         inc_w;
    logic [NUM_METRICS-1:0][NT-1:0]         dec_w;
    logic [NUM_METRICS-1:0][NT-1:0][CW-1:0] cnt_w;
    logic [NT-1:0][CW-1:0]                  key_w;

    fetch_pol_e     mode_q;
    fetch_pol_e     mode_d;
    logic [IDW-1:0] ptr_q;

    logic [NT-1:0]  rank_grant;
    logic [IDW-1:0] rank_top;
    logic [IDW-1:0] rank_last;
    logic           rank_any;

    assign inc_w[MET_OCC]  = inst_inc_i;
    assign inc_w[MET_BR]   = br_inc_i;
    assign inc_w[MET_MISS] = miss_inc_i;
    assign dec_w[MET_OCC]  = inst_dec_i;
    assign dec_w[MET_BR]   = br_dec_i;
    assign dec_w[MET_MISS] = miss_dec_i;

    // One saturating counter per metric and thread.
    for (genvar m = 0; m < NUM_METRICS; m++) begin : g_metric
        for (genvar t = 0; t < NT; t++) begin : g_thread
            fetch_sat_ctr #(
                .CW (CW)
            ) u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .inc_i (inc_w[m][t]),
                .dec_i (dec_w[m][t]),
                .cnt_o (cnt_w[m][t])
            );
        end
    end

    // Next-state logic: the policy code names the target state.
    always_comb begin
        unique case (policy_i)
            2'd0:    mode_d = POL_OCC;
            2'd1:    mode_d = POL_BRANCH;
            2'd2:    mode_d = POL_MISS;
            default: mode_d = POL_ROTATE;
        endcase
    end

    // State register: the policy is only taken at a clock edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= POL_OCC;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Ranking key for the active state; rotation uses equal keys so the
    // rotation order alone decides.
    always_comb begin
        unique case (mode_q)
            POL_OCC:    key_w = cnt_w[MET_OCC];
            POL_BRANCH: key_w = cnt_w[MET_BR];
            POL_MISS:   key_w = cnt_w[MET_MISS];
            POL_ROTATE: key_w = '0;
            default:    key_w = '0;
        endcase
    end

    fetch_rank #(
        .NT    (NT),
        .CW    (CW),
        .SLOTS (SLOTS)
    ) u_rank (
        .key_i   (key_w),
        .elig_i  (~stall_i),
        .ptr_i   (ptr_q),
        .grant_o (rank_grant),
        .top_o   (rank_top),
        .last_o  (rank_last),
        .any_o   (rank_any)
    );

    // Output process: registered grant and rotation pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o   <= '0;
            top_id_o  <= '0;
            top_vld_o <= 1'b0;
            ptr_q     <= PTR_RST;
        end else begin
            grant_o   <= rank_grant;
            top_id_o  <= rank_top;
            top_vld_o <= rank_any;
            if (rank_any) begin
                ptr_q <= rank_last;
            end
        end
    end

endmodule

// File: rtl/fetch_prio_sel_chk.sv
module fetch_prio_sel_chk #(
    parameter int NT    = 4,
    parameter int SLOTS = 2,
    localparam int IDW  = (NT > 1) ? $clog2(NT) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NT-1:0]  stall_i,
    input logic [NT-1:0]  grant_o,
    input logic [IDW-1:0] top_id_o,
    input logic           top_vld_o
);

    logic armed;

    // Set once one full cycle has passed since reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    AST_NO_STALLED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((grant_o & $past(stall_i)) == '0)); // R9

    AST_IDLE_ALL_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (&$past(stall_i))) |-> !top_vld_o); // R9

    AST_VLD_IFF_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld_o == (grant_o != '0)); // R9

    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= SLOTS); // R4

    AST_FILL_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($countones(~$past(stall_i)) >= SLOTS)) |->
            ($countones(grant_o) == SLOTS)); // R4

    AST_TOP_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld_o |-> grant_o[top_id_o]); // R8

endmodule

bind fetch_prio_sel fetch_prio_sel_chk #(
    .NT    (NT),
    .SLOTS (SLOTS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_i   (stall_i),
    .grant_o   (grant_o),
    .top_id_o  (top_id_o),
    .top_vld_o (top_vld_o)
);

// File: tb/test_fetch_prio_sel.sv
`timescale 1ns/1ps
module test_fetch_prio_sel;

    localparam int NT    = 4;
    localparam int CW    = 6;
    localparam int SLOTS = 2;
    localparam int IDW   = 2;
    localparam int CMAX  = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [1:0]     pol;
    logic [NT-1:0]  stall;
    logic [NT-1:0]  inc_v [3];
    logic [NT-1:0]  dec_v [3];
    logic [NT-1:0]  grant_o;
    logic [IDW-1:0] top_id_o;
    logic           top_vld_o;

    always #10 clk = ~clk;

    fetch_prio_sel #(
        .NT    (NT),
        .CW    (CW),
        .SLOTS (SLOTS)
    ) i_fetch_prio_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_i   (pol),
        .stall_i    (stall),
        .inst_inc_i (inc_v[0]),
        .inst_dec_i (dec_v[0]),
        .br_inc_i   (inc_v[1]),
        .br_dec_i   (dec_v[1]),
        .miss_inc_i (inc_v[2]),
        .miss_dec_i (dec_v[2]),
        .grant_o    (grant_o),
        .top_id_o   (top_id_o),
        .top_vld_o  (top_vld_o)
    );

    int        m_cnt [3][NT];
    int        m_mode;
    int        m_ptr;
    int        n_tests = 0;
    int        n_fail  = 0;
    bit        done    = 1'b0;
    bit [31:0] rng     = 32'h1357_9bdf;

    function automatic bit [31:0] rnd();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic logic [NT-1:0] rvec(input int p16);
        logic [NT-1:0] v;
        for (int t = 0; t < NT; t++) v[t] = ((rnd() % 16) < p16);
        return v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Requirement-level ranking model: SLOTS rounds of "smallest key, first
    // in rotation after the pointer"; rotation policy treats all keys as equal.
    task automatic model_pick(input logic [NT-1:0] stl, output logic [NT-1:0] g,
                              output int top, output bit vld, output int last);
        bit found;
        int best;
        int key;
        int bkey;
        g = '0; top = 0; vld = 1'b0; last = m_ptr;
        for (int s = 0; s < SLOTS; s++) begin
            found = 1'b0; best = 0; bkey = 0;
            for (int o = 1; o <= NT; o++) begin
                int idx;
                idx = (m_ptr + o) % NT;
                key = (m_mode == 3) ? 0 : m_cnt[m_mode][idx];
                if (!stl[idx] && !g[idx] && (!found || key < bkey)) begin
                    found = 1'b1; best = idx; bkey = key;
                end
            end
            if (found) begin
                g[best] = 1'b1;
                last = best;
                if (s == 0) begin top = best; vld = 1'b1; end
            end
        end
    endtask

    function automatic string mode_tag(input int md);
        case (md)
            0:       return "R4";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // One clock: rank from pre-edge model state (R11), then apply events and
    // policy sampled at the same edge, then compare at the falling edge.
    task automatic do_cycle(input string tag);
        logic [NT-1:0] eg;
        int et;
        int el;
        bit ev;
        int used;
        string req;
        @(posedge clk);
        used = m_mode;
        model_pick(stall, eg, et, ev, el);
        if (ev) m_ptr = el;
        for (int m = 0; m < 3; m++) begin
            for (int t = 0; t < NT; t++) begin
                if (inc_v[m][t] && !dec_v[m][t] && m_cnt[m][t] < CMAX) m_cnt[m][t]++;
                else if (dec_v[m][t] && !inc_v[m][t] && m_cnt[m][t] > 0) m_cnt[m][t]--;
            end
        end
        m_mode = int'(pol);
        @(negedge clk);
        req = {tag, "/", (ev ? mode_tag(used) : "R9"), "/R11"};
        chk(req, "grant", int'(grant_o), int'(eg));
        chk(req, "top_vld", int'(top_vld_o), int'(ev));
        if (ev) chk(req, "top_id", int'(top_id_o), et);
    endtask

    // pol_sel: 0..3 fixed, -1 random per cycle, -2 step every 50 cycles.
    task automatic run(input string tag, input int n, input int inc_p, input int dec_p,
                       input int stall_p, input int pol_sel);
        for (int c = 0; c < n; c++) begin
            for (int m = 0; m < 3; m++) begin
                inc_v[m] = rvec(inc_p);
                dec_v[m] = rvec(dec_p);
            end
            stall = rvec(stall_p);
            if (pol_sel >= 0)       pol = 2'(pol_sel);
            else if (pol_sel == -1) pol = 2'(rnd() % 4);
            else                    pol = 2'((c / 50) % 4);
            do_cycle(tag);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        rst_n = 1'b0;
        pol   = 2'd0;
        stall = '0;
        for (int m = 0; m < 3; m++) begin
            inc_v[m] = '0;
            dec_v[m] = '0;
            for (int t = 0; t < NT; t++) m_cnt[m][t] = 0;
        end
        m_mode = 0;
        m_ptr  = NT - 1;
        repeat (3) @(negedge clk);
        // R1: idle outputs while reset is held
        chk("R1", "grant", int'(grant_o), 0);
        chk("R1", "top_vld", int'(top_vld_o), 0);
        rst_n = 1'b1;

        // R1/R8: no events, no stalls: rotation from thread 0 among equal counts
        run("R1", 6, 0, 0, 0, 0);
        // R2: mixed single and simultaneous increment/decrement pulses
        run("R2", 300, 8, 8, 0, 0);
        // R3: drive counters into the upper rail under every policy
        run("R3", 400, 14, 1, 2, -2);
        // R2: both pulses on every counter each cycle must cancel
        run("R2", 30, 16, 16, 0, -2);
        // R3: drive counters down into the lower rail
        run("R3", 300, 1, 14, 2, -2);
        // R9: sweep every stall pattern under every policy
        for (int pm = 0; pm < 4; pm++) begin
            for (int sv = 0; sv < (1 << NT); sv++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int m = 0; m < 3; m++) begin
                        inc_v[m] = rvec(6);
                        dec_v[m] = rvec(5);
                    end
                    stall = NT'(sv);
                    pol   = 2'(pm);
                    do_cycle("R9");
                end
            end
        end
        // R7: plain rotation with random stalls
        run("R7", 200, 6, 6, 4, 3);
        // R10: policy changes every cycle while counts keep moving
        run("R10", 400, 7, 6, 3, -1);
        // R8: drain to equal counts, then ties decided by rotation alone
        run("R8", 70, 0, 16, 0, 0);
        run("R8", 20, 0, 0, 0, 0);
        run("R8", 20, 0, 0, 0, 2);
        run("R8", 40, 4, 3, 6, -1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule